// File: doc/BRIEF.md
# Break and Return-from-Interrupt Stack Sequencer

This block runs the two stack-heavy sequences of a small 8-bit processor with a 16-bit address space and a stack in page one. The first is the software break. It skips the ignored operand byte, saves the return address and the status byte on the stack, fetches a new program counter from the break vector, then masks interrupts and leaves decimal mode. The second is the return from interrupt. It restores the status byte and then the program counter from the stack. The block holds the program counter, the stack pointer and the status byte itself. It also loads the program counter from the reset vector as soon as reset is released.

An instruction decoder pulses `start` with `op_ret` choosing the sequence. The sequencer then owns a synchronous memory port and makes one access per clock. Read data returns on the clock after the address is presented. A one-cycle `done` pulse marks the end, and by then the register outputs already show their final values. A new `start` may be given in the same cycle as `done`.

Top module: `trap_stack_seq`

## Requirements
- R1: While reset is held, the stack pointer reads 0xFF, the status reads 0x30, the write enable is low and the address is 0xFFFC. After release the sequencer reads 0xFFFD, spends one cycle without an access, and loads the program counter as {byte at 0xFFFD, byte at 0xFFFC}.
- R2: A break writes (PC+1) mod 65536 to the stack, high byte first and then low byte. Each write goes to 0x0100 + S, after which S decrements modulo 256.
- R3: The third break write stores the status byte exactly as held. Bit 4 (break) and bit 5 are always 1 in it.
- R4: A start with `op_ret` = 0 begins a break. The first cycle after start is a read of the address held in the program counter. The sequence then takes the push, vector and finish cycles in fixed order, so that `done` comes 8 cycles after the start edge.
- R5: A break loads the program counter little-endian, reading 0xFFFE in the fifth cycle and 0xFFFF in the sixth.
- R6: At the end of a break, status bit 2 (interrupt mask) is 1 and bit 3 (decimal) is 0, and all other status bits keep their values.
- R7: A start with `op_ret` = 1 begins a return. It makes three reads from 0x0100 + S, and before each read S increments modulo 256. The first byte, ORed with 0x30, becomes the status. The second and third bytes become the program counter low and high bytes.
- R8: `done` is high for exactly one cycle. It comes 5 cycles after a return start and 3 cycles after reset release. At that cycle the program counter, stack pointer and status already hold their new values.
- R9: A start seen while a sequence (including the post-reset load) is in progress has no effect on the bus, the registers or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence when idle |
| op_ret | input | 1 | 0 = break entry, 1 = return from interrupt |
| mem_rdata | input | 8 | Read data, valid the cycle after its address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| status | output | 8 | Status byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The stack pointer wrap is hard to reach from the ports, because the pointer starts at 0xFF and moves only through full sequences. The bench gets there in steps. It places a hand-written frame at 0x0100 to 0x0102 and runs a return from 0xFF, so that the pulls cross from 0xFF to 0x00. It then runs a break from a program counter of 0xFFFF, so that the pushed return address wraps to 0x0000 and the final push lands at 0x0100 and leaves S at 0xFF. Stray starts are placed in the middle of a break, a return and the post-reset load. A start is also given on the `done` cycle itself, to show where a new sequence may first be accepted.

// File: rtl/trap_pkg.sv
// Shared definitions for the break / return stack sequencer.
// Assumes an 8-bit data path and a 16-bit address space.
package trap_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Status bit positions the sequencer touches
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam logic [DATA_W-1:0] STATUS_FORCED = 8'h30;

    // Sequencer states; each non-idle, non-finish state makes one memory access
    typedef enum logic [3:0] {
        ST_RVEC_LO,
        ST_RVEC_HI,
        ST_RVEC_FIN,
        ST_IDLE,
        ST_BRK_SKIP,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_BVEC_LO,
        ST_BVEC_HI,
        ST_BRK_FIN,
        ST_PULL_ST,
        ST_PULL_LO,
        ST_PULL_HI,
        ST_RTI_FIN
    } seq_state_e;

endpackage

// File: rtl/trap_seq_fsm.sv
// State sequencing for reset-vector load, break entry and return.
// Assumes start/op_ret are sampled only in ST_IDLE; done is registered and
// appears the cycle after a finish state, once the registers are updated.
module trap_seq_fsm
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       op_ret,
    output seq_state_e state_q,
    output logic       done
);

    seq_state_e state_d;

    // Next-state selection: fixed chains, branching only from idle
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RVEC_LO:  state_d = ST_RVEC_HI;
            ST_RVEC_HI:  state_d = ST_RVEC_FIN;
            ST_RVEC_FIN: state_d = ST_IDLE;
            ST_IDLE:     if (start) state_d = op_ret ? ST_PULL_ST : ST_BRK_SKIP;
            ST_BRK_SKIP: state_d = ST_PUSH_HI;
            ST_PUSH_HI:  state_d = ST_PUSH_LO;
            ST_PUSH_LO:  state_d = ST_PUSH_ST;
            ST_PUSH_ST:  state_d = ST_BVEC_LO;
            ST_BVEC_LO:  state_d = ST_BVEC_HI;
            ST_BVEC_HI:  state_d = ST_BRK_FIN;
            ST_BRK_FIN:  state_d = ST_IDLE;
            ST_PULL_ST:  state_d = ST_PULL_LO;
            ST_PULL_LO:  state_d = ST_PULL_HI;
            ST_PULL_HI:  state_d = ST_RTI_FIN;
            ST_RTI_FIN:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register; reset parks on the first reset-vector read
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RVEC_LO;
        else        state_q <= state_d;
    end

    // Completion pulse, one cycle after any finish state
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state_q == ST_RVEC_FIN) || (state_q == ST_BRK_FIN)
                            || (state_q == ST_RTI_FIN);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != ST_IDLE) |=>
        (state_q != ST_BRK_SKIP && state_q != ST_PULL_ST)); // R9

endmodule

// File: rtl/trap_bus_drv.sv
// Memory port driver: maps the current state and register values to one
// address / write per cycle. Purely combinational; assumes reads are
// registered by the memory, so data returns one cycle later.
module trap_bus_drv
    import trap_pkg::*;
#(
    parameter logic [7:0]        STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFFFC,
    parameter logic [ADDR_W-1:0] BRK_VEC    = 16'hFFFE
) (
    input  seq_state_e        state_q,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [7:0]        sp_q,
    input  logic [DATA_W-1:0] psw_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);

    logic [ADDR_W-1:0] ret_addr;
    logic [7:0]        sp_next;

    // Return address pushed by a break skips the ignored operand byte
    assign ret_addr = pc_q + 16'd1;
    // Pulls address the slot above the current top
    assign sp_next  = sp_q + 8'd1;

    // Address, data and enable per state
    always_comb begin
        mem_addr  = pc_q;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (state_q)
            ST_RVEC_LO: mem_addr = RST_VEC;
            ST_RVEC_HI: mem_addr = RST_VEC + 16'd1;
            ST_BRK_SKIP: mem_addr = pc_q;
            ST_PUSH_HI: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = ret_addr[15:8];
                mem_we    = 1'b1;
            end
            ST_PUSH_LO: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = ret_addr[7:0];
                mem_we    = 1'b1;
            end
            ST_PUSH_ST: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = psw_q;
                mem_we    = 1'b1;
            end
            ST_BVEC_LO: mem_addr = BRK_VEC;
            ST_BVEC_HI: mem_addr = BRK_VEC + 16'd1;
            ST_PULL_ST, ST_PULL_LO, ST_PULL_HI: mem_addr = {STACK_PAGE, sp_next};
            default: ;
        endcase
    end

endmodule

// File: rtl/trap_regs.sv
// Architectural registers touched by the sequences: program counter,
// stack pointer, status, and a holding byte for the low half of a
// fetched word. Assumes read data for an access arrives in the next state.
module trap_regs
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_q,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_q,
    output logic [7:0]        sp_q,
    output logic [DATA_W-1:0] psw_q
);

    logic [DATA_W-1:0] lo_q;
    logic              pulling;

    assign pulling = (state_q == ST_PULL_ST) || (state_q == ST_PULL_LO)
                     || (state_q == ST_PULL_HI);

    // Register updates keyed to the state whose read data is on mem_rdata
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= 8'hFF;
            psw_q <= STATUS_FORCED;
            lo_q  <= '0;
        end else begin
            case (state_q)
                ST_RVEC_HI, ST_BVEC_HI: lo_q <= mem_rdata;
                ST_RVEC_FIN, ST_RTI_FIN: pc_q <= {mem_rdata, lo_q};
                ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST: sp_q <= sp_q - 8'd1;
                ST_BRK_FIN: begin
                    pc_q         <= {mem_rdata, lo_q};
                    psw_q[FLG_I] <= 1'b1;
                    psw_q[FLG_D] <= 1'b0;
                end
                ST_PULL_ST: sp_q <= sp_q + 8'd1;
                ST_PULL_LO: begin
                    sp_q  <= sp_q + 8'd1;
                    psw_q <= mem_rdata | STATUS_FORCED;
                end
                ST_PULL_HI: begin
                    sp_q <= sp_q + 8'd1;
                    lo_q <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    AST_STATUS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        psw_q[5:4] == 2'b11); // R7

    AST_BRK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK_FIN) |=> (psw_q[FLG_I] && !psw_q[FLG_D])); // R6

    AST_PULL_INC: assert property (@(posedge clk) disable iff (!rst_n)
        pulling |=> (sp_q == $past(sp_q) + 8'd1)); // R7

endmodule

// File: rtl/trap_stack_seq.sv
// Top of the break / return stack sequencer. Loads the PC from the reset
// vector after reset, then accepts break (op_ret=0) or return (op_ret=1)
// requests, one memory access per clock on a port with one-cycle read latency.
module trap_stack_seq
    import trap_pkg::*;
#(
    parameter logic [7:0]        STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] RST_VEC    = 16'hFFFC,
    parameter logic [ADDR_W-1:0] BRK_VEC    = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_ret,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] pc,
    output logic [7:0]        sp,
    output logic [DATA_W-1:0] status,
    output logic              done
);

    seq_state_e state_q;

    trap_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_ret  (op_ret),
        .state_q (state_q),
        .done    (done)
    );

    trap_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .mem_rdata (mem_rdata),
        .pc_q      (pc),
        .sp_q      (sp),
        .psw_q     (status)
    );

    trap_bus_drv #(
        .STACK_PAGE (STACK_PAGE),
        .RST_VEC    (RST_VEC),
        .BRK_VEC    (BRK_VEC)
    ) u_bus (
        .state_q   (state_q),
        .pc_q      (pc),
        .sp_q      (sp),
        .psw_q     (status),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) - 8'd1)); // R2

    AST_WRITE_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we); // R8

endmodule

// File: tb/trap_stack_seq_test.sv
// Cycle-by-cycle reference bench for trap_stack_seq.
module trap_stack_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_ret = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  status;
    logic        done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_stack_seq uut (
        .clk (clk), .rst_n (rst_n), .start (start), .op_ret (op_ret),
        .mem_rdata (mem_rdata), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_we (mem_we), .pc (pc), .sp (sp), .status (status), .done (done)
    );

    // Sparse memory with registered read
    logic [7:0] mem [int];
    function automatic logic [7:0] mrd(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction
    always @(posedge clk) begin
        mem_rdata <= mrd(int'(mem_addr));
        if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    end

    // Expected per-cycle bus activity
    typedef struct packed {
        logic        chk;
        logic [15:0] addr;
        logic        we;
        logic [7:0]  wd;
        logic        dn;
    } exp_t;
    exp_t  eq[$];
    string tq[$];

    // Model registers and values due at the done cycle
    logic [15:0] m_pc;
    logic [7:0]  m_sp, m_psw;
    logic [15:0] p_pc;
    logic [7:0]  p_sp, p_psw;
    string       t_pc, t_sp, t_psw;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic c, input logic [15:0] a, input logic w,
                        input logic [7:0] d, input logic dn, input string tag);
        exp_t e;
        e.chk = c; e.addr = a; e.we = w; e.wd = d; e.dn = dn;
        eq.push_back(e);
        tq.push_back(tag);
    endtask

    // One clock: compare outputs with the model at the falling edge
    task automatic tick();
        exp_t  e;
        string t;
        @(negedge clk);
        if (eq.size() > 0) begin
            e = eq.pop_front();
            t = tq.pop_front();
            chk(t, "we", mem_we, e.we);
            chk(e.dn ? "R8" : t, "done", done, e.dn);
            if (e.chk) begin
                chk(t, "addr", mem_addr, e.addr);
                if (e.we) chk(t, "wdata", mem_wdata, e.wd);
            end
            if (e.dn) begin
                m_pc = p_pc; m_sp = p_sp; m_psw = p_psw;
                chk(t_pc, "pc", pc, m_pc);
                chk(t_sp, "sp", sp, m_sp);
                chk(t_psw, "status", status, m_psw);
            end
        end else begin
            // idle: registers steady, no write, no done (R9 covers stray starts)
            chk("R9", "idle we", mem_we, 1'b0);
            chk("R8", "idle done", done, 1'b0);
            chk("R9", "idle pc", pc, m_pc);
            chk("R9", "idle sp", sp, m_sp);
            chk("R9", "idle status", status, m_psw);
        end
    endtask

    // Run queued expectations; optionally pulse a stray start after tick 'poke'
    task automatic run_seq(input int poke, input logic poke_ret);
        int j = 0;
        while (eq.size() > 0) begin
            tick();
            j++;
            if (j == poke && eq.size() > 0) begin
                start = 1'b1;
                op_ret = poke_ret;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset(input int poke);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset sp", sp, 8'hFF);
        chk("R1", "reset status", status, 8'h30);
        chk("R1", "reset we", mem_we, 1'b0);
        chk("R1", "reset done", done, 1'b0);
        chk("R1", "reset addr", mem_addr, 16'hFFFC);
        rst_n = 1'b1;
        push(1, 16'hFFFD, 0, 8'h00, 0, "R1");
        push(0, 16'h0000, 0, 8'h00, 0, "R1");
        push(0, 16'h0000, 0, 8'h00, 1, "R1");
        p_pc = {mrd(16'hFFFD), mrd(16'hFFFC)};
        p_sp = 8'hFF; p_psw = 8'h30;
        t_pc = "R1"; t_sp = "R1"; t_psw = "R1";
        run_seq(poke, 1'b0);
    endtask

    // Break: skip read, three pushes, vector pair, finish, done (R4 timing)
    task automatic do_break(input int poke);
        logic [15:0] ra;
        logic [7:0]  s;
        ra = m_pc + 16'd1;
        s = m_sp;
        start = 1'b1; op_ret = 1'b0;
        push(1, m_pc, 0, 8'h00, 0, "R4");
        push(1, {8'h01, s}, 1, ra[15:8], 0, "R2");
        s = s - 8'd1;
        push(1, {8'h01, s}, 1, ra[7:0], 0, "R2");
        s = s - 8'd1;
        push(1, {8'h01, s}, 1, m_psw, 0, "R3");
        s = s - 8'd1;
        push(1, 16'hFFFE, 0, 8'h00, 0, "R5");
        push(1, 16'hFFFF, 0, 8'h00, 0, "R5");
        push(0, 16'h0000, 0, 8'h00, 0, "R4");
        push(0, 16'h0000, 0, 8'h00, 1, "R4");
        p_pc = {mrd(16'hFFFF), mrd(16'hFFFE)};
        p_sp = s;
        p_psw = (m_psw | 8'h04) & ~8'h08;
        t_pc = "R5"; t_sp = "R2"; t_psw = "R6";
        run_seq(poke, 1'b1);
    endtask

    // Return: three pulls with pre-increment, finish, done
    task automatic do_return(input int poke);
        logic [7:0] s1, s2, s3;
        s1 = m_sp + 8'd1; s2 = m_sp + 8'd2; s3 = m_sp + 8'd3;
        start = 1'b1; op_ret = 1'b1;
        push(1, {8'h01, s1}, 0, 8'h00, 0, "R7");
        push(1, {8'h01, s2}, 0, 8'h00, 0, "R7");
        push(1, {8'h01, s3}, 0, 8'h00, 0, "R7");
        push(0, 16'h0000, 0, 8'h00, 0, "R7");
        push(0, 16'h0000, 0, 8'h00, 1, "R8");
        p_psw = mrd({16'h0001, s1}) | 8'h30;
        p_pc = {mrd({16'h0001, s3}), mrd({16'h0001, s2})};
        p_sp = s3;
        t_pc = "R7"; t_sp = "R7"; t_psw = "R7";
        run_seq(poke, 1'b0);
    endtask

    initial begin
        m_pc = '0; m_sp = 8'hFF; m_psw = 8'h30;
        mem[16'hFFFC] = 8'h34; mem[16'hFFFD] = 8'h12;
        mem[16'hFFFE] = 8'h00; mem[16'hFFFF] = 8'h80;

        do_reset(1);            // R1, with a stray start during the load (R9)
        idle(2);
        do_break(3);            // R2..R6, stray return start mid-sequence (R9)
        idle(2);
        do_return(2);           // R7, restores the frame just pushed
        idle(1);

        // frame with bits 4/5 clear, pulled across the 0xFF->0x00 wrap (R7)
        mem[16'h0100] = 8'h0C; mem[16'h0101] = 8'hFF; mem[16'h0102] = 8'hFF;
        do_return(0);
        do_break(0);            // back-to-back on done; PC+1 wraps to 0000 (R2)
        do_return(0);
        idle(1);

        mem[16'h0103] = 8'hC1; mem[16'h0104] = 8'h78; mem[16'h0105] = 8'h56;
        do_return(0);           // status 0xF1
        mem[16'hFFFE] = 8'hCD; mem[16'hFFFF] = 8'hAB;
        do_break(5);            // flags N,V,C survive, I set, D clear (R6)
        do_return(3);           // PC 0x5679 back from the stack
        idle(3);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule